// File: doc/BRIEF.md
# Six-Port Circuit-Switched Link Arbiter

This block controls a single-hop crossbar of six bidirectional ports. Any port may ask for a link to any other port by presenting a token. The token carries a purpose code, a short route list with an index that picks the target entry, and a transfer length in 32-bit words. In each cycle the arbiter looks at all presented tokens. It grants a link when both ends are free and sends back an acknowledge one cycle later. In every other case it sends back a not-acknowledge. A requester that is refused must retry later, because nothing is queued. A granted link stays allocated for exactly as many cycles as its length gives, and it then frees itself.

A preempt token names a port and tears down whatever link that port belongs to, so both ends become idle on the next edge. While a link is up, a word crossbar carries data both ways between its two ends. Each direction uses a valid/ready stream. The sender's ready is the far receiver's ready, passed through combinationally, so back-pressure reaches the sender in the same cycle. The link's hold time counts cycles whether or not any words move. Ports without a link see neither valid nor ready.

Top module: `xbar_link_ctrl`

## Requirements
- R1: After reset, all ports are idle (`port_busy` low) and no response is valid. This lasts until the first token is accepted.
- R2: A port is busy while it is either end of a live link. A request whose own port or target port is busy is answered with not-acknowledge. A port is never part of two links at once.
- R3: When several grantable requests arrive in the same cycle, they are examined from port 0 upward. A lower-numbered port's grant makes its two ports unavailable to higher-numbered requests in that cycle.
- R4: A granted link holds both its ports busy for exactly `req_len` cycles, starting the cycle after the request. A request with length 0 is answered with not-acknowledge.
- R5: The target port is the PORT_W-bit route entry at bit offset `req_index*PORT_W` of `req_route`. A target value of NPORTS or more is answered with not-acknowledge.
- R6: Purpose codes are 2'b00 request, 2'b01 acknowledge, 2'b10 not-acknowledge and 2'b11 preempt. An incoming token coded acknowledge or not-acknowledge is ignored: it produces no response and changes no port state.
- R7: A preempt aimed at a busy port is acknowledged, and both ends of that link are idle from the next cycle. A preempt aimed at an idle or invalid port is answered with not-acknowledge. A request made in the same cycle as a preempt still sees the link as busy.
- R8: A request whose target is its own port is answered with not-acknowledge.
- R9: Every request or preempt is answered exactly once, in the following cycle, on the same port's `rsp_valid`/`rsp_kind`. The answer uses code 2'b01 (acknowledge) or 2'b10 (not-acknowledge).
- R10: While a link joins ports a and b, `out_data`/`out_valid` of each end carry the other end's `in_data`/`in_valid`, and each end's `in_ready` follows the far end's `out_ready`. On an idle port, `out_valid`, `out_data` and `in_ready` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORTS | Token present on each port |
| req_kind | input | NPORTS x 2 | Token purpose code per port |
| req_route | input | NPORTS x HOPS*PORT_W | Route list per port |
| req_index | input | NPORTS x IDX_W | Route entry selector per port |
| req_len | input | NPORTS x LEN_W | Link length in words (hold cycles) |
| rsp_valid | output | NPORTS | Response present, one cycle after the token |
| rsp_kind | output | NPORTS x 2 | Response code: acknowledge or not-acknowledge |
| port_busy | output | NPORTS | Port belongs to a live link |
| in_valid | input | NPORTS | Word offered by each port's sender |
| in_ready | output | NPORTS | Far end accepts the word |
| in_data | input | NPORTS x DATA_W | Word from each port's sender |
| out_valid | output | NPORTS | Word delivered to each port's receiver |
| out_ready | input | NPORTS | Receiver at each port can take a word |
| out_data | output | NPORTS x DATA_W | Word delivered to each port |

## Verification
The assertions watch some properties on every cycle. Every live link must be symmetric: its two ends name each other and differ. A new link may never be loaded onto a busy port. Hold counters must step down by one per cycle unless a preempt clears them. A preempted port must be idle on the next edge. Every response must follow a token and carry only an acknowledge or a not-acknowledge code. Three properties need the bench's scenarios: which of several same-cycle requests wins, the exact cycle a link expires, and how a preempt interacts with a same-cycle request. The bench compares these against a behavioural per-port model on every clock, and it also checks the two-way word path and its ready pass-through.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    TK_REQ     = 2'b00,
    TK_ACK     = 2'b01,
    TK_NACK    = 2'b10,
    TK_PREEMPT = 2'b11
  } tok_kind_e;
endpackage

// File: rtl/xbar_route_decode.sv
module xbar_route_decode #(
  parameter int NPORTS = 6,
  parameter int HOPS   = 4,
  parameter int PORT_W = 3,
  parameter int IDX_W  = 2
) (
  input  logic [NPORTS-1:0][HOPS*PORT_W-1:0] route,
  input  logic [NPORTS-1:0][IDX_W-1:0]       index,
  output logic [NPORTS-1:0][PORT_W-1:0]      dest,
  output logic [NPORTS-1:0]                  dest_ok
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [PORT_W-1:0] sel;
    always_comb begin
      sel = '0;
      for (int h = 0; h < HOPS; h++) begin
        if (index[p] == IDX_W'(h)) sel = route[p][h*PORT_W +: PORT_W];
      end
    end
    assign dest[p]    = sel;
    assign dest_ok[p] = (int'(sel) < NPORTS);
  end
endmodule

// File: rtl/xbar_arbiter.sv
module xbar_arbiter
  import xbar_pkg::*;
#(
  parameter int NPORTS = 6,
  parameter int PORT_W = 3,
  parameter int LEN_W  = 8
) (
  input  logic [NPORTS-1:0]              req_valid,
  input  logic [NPORTS-1:0][1:0]         req_kind,
  input  logic [NPORTS-1:0][PORT_W-1:0]  dest,
  input  logic [NPORTS-1:0]              dest_ok,
  input  logic [NPORTS-1:0][LEN_W-1:0]   req_len,
  input  logic [NPORTS-1:0]              busy,
  output logic [NPORTS-1:0]              grant,
  output logic [NPORTS-1:0]              kill,
  output logic [NPORTS-1:0]              rsp_v_d,
  output logic [NPORTS-1:0][1:0]         rsp_k_d
);
  logic [NPORTS-1:0] taken;

  // Ports are visited from 0 upward; each grant marks both ends taken so
  // that higher-numbered requesters see them as unavailable.
  always_comb begin
    taken   = busy;
    grant   = '0;
    kill    = '0;
    rsp_v_d = '0;
    rsp_k_d = '0;
    for (int i = 0; i < NPORTS; i++) begin
      rsp_k_d[i] = TK_NACK;
      if (req_valid[i]) begin
        if (req_kind[i] == TK_REQ) begin
          rsp_v_d[i] = 1'b1;
          if (dest_ok[i] && dest[i] != PORT_W'(i) && req_len[i] != '0 &&
              !taken[i] && !taken[dest[i]]) begin
            grant[i]       = 1'b1;
            taken[i]       = 1'b1;
            taken[dest[i]] = 1'b1;
            rsp_k_d[i]     = TK_ACK;
          end
        end else if (req_kind[i] == TK_PREEMPT) begin
          rsp_v_d[i] = 1'b1;
          if (dest_ok[i] && busy[dest[i]]) begin
            kill[dest[i]] = 1'b1;
            rsp_k_d[i]    = TK_ACK;
          end
        end
      end
    end
  end
endmodule

// File: rtl/xbar_link_table.sv
module xbar_link_table #(
  parameter int NPORTS = 6,
  parameter int PORT_W = 3,
  parameter int LEN_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NPORTS-1:0]              grant,
  input  logic [NPORTS-1:0][PORT_W-1:0]  dest,
  input  logic [NPORTS-1:0][LEN_W-1:0]   req_len,
  input  logic [NPORTS-1:0]              kill,
  output logic [NPORTS-1:0]              busy,
  output logic [NPORTS-1:0][PORT_W-1:0]  peer
);
  logic [NPORTS-1:0][LEN_W-1:0]  rem;
  logic [NPORTS-1:0]             set;
  logic [NPORTS-1:0][LEN_W-1:0]  set_len;
  logic [NPORTS-1:0][PORT_W-1:0] set_peer;
  logic [NPORTS-1:0]             clr;

  // Both ends of a new link load the same hold count and name each other.
  always_comb begin
    set      = '0;
    set_len  = '0;
    set_peer = '0;
    for (int i = 0; i < NPORTS; i++) begin
      if (grant[i]) begin
        set[i]            = 1'b1;
        set_len[i]        = req_len[i];
        set_peer[i]       = dest[i];
        set[dest[i]]      = 1'b1;
        set_len[dest[i]]  = req_len[i];
        set_peer[dest[i]] = PORT_W'(i);
      end
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_entry
    assign busy[p] = (rem[p] != '0);
    assign clr[p]  = busy[p] && (kill[p] || kill[peer[p]]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rem[p]  <= '0;
        peer[p] <= '0;
      end else if (set[p]) begin
        rem[p]  <= set_len[p];
        peer[p] <= set_peer[p];
      end else if (clr[p]) begin
        rem[p]  <= '0;
      end else if (busy[p]) begin
        rem[p]  <= rem[p] - 1'b1;
      end
    end

    // R2: a live link is a symmetric pair of two distinct ports.
    a_r2_link_symmetric: assert property (@(posedge clk) disable iff (!rst_n)
      busy[p] |-> (busy[peer[p]] && peer[peer[p]] == PORT_W'(p) && peer[p] != PORT_W'(p)));
    // R2: a link is only loaded onto an idle port.
    a_r2_set_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
      set[p] |-> !busy[p]);
    // R4: hold count steps down by one per cycle.
    a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (rem[p] > LEN_W'(1) && !clr[p]) |=> (rem[p] == $past(rem[p]) - 1'b1));
    // R7: a preempted port is idle on the next edge.
    a_r7_preempt_frees: assert property (@(posedge clk) disable iff (!rst_n)
      clr[p] |=> !busy[p]);
  end
endmodule

// File: rtl/xbar_data_mux.sv
module xbar_data_mux #(
  parameter int NPORTS = 6,
  parameter int PORT_W = 3,
  parameter int DATA_W = 32
) (
  input  logic [NPORTS-1:0]              busy,
  input  logic [NPORTS-1:0][PORT_W-1:0]  peer,
  input  logic [NPORTS-1:0]              in_valid,
  input  logic [NPORTS-1:0][DATA_W-1:0]  in_data,
  input  logic [NPORTS-1:0]              out_ready,
  output logic [NPORTS-1:0]              in_ready,
  output logic [NPORTS-1:0]              out_valid,
  output logic [NPORTS-1:0][DATA_W-1:0]  out_data
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_lane
    assign out_valid[p] = busy[p] && in_valid[peer[p]];
    assign out_data[p]  = busy[p] ? in_data[peer[p]] : '0;
    assign in_ready[p]  = busy[p] && out_ready[peer[p]];
  end
endmodule

// File: rtl/xbar_link_ctrl.sv
module xbar_link_ctrl
  import xbar_pkg::*;
#(
  parameter int NPORTS = 6,
  parameter int HOPS   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32,
  localparam int PORT_W = $clog2(NPORTS),
  localparam int IDX_W  = $clog2(HOPS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NPORTS-1:0]                  req_valid,
  input  logic [NPORTS-1:0][1:0]             req_kind,
  input  logic [NPORTS-1:0][HOPS*PORT_W-1:0] req_route,
  input  logic [NPORTS-1:0][IDX_W-1:0]       req_index,
  input  logic [NPORTS-1:0][LEN_W-1:0]       req_len,
  output logic [NPORTS-1:0]                  rsp_valid,
  output logic [NPORTS-1:0][1:0]             rsp_kind,
  output logic [NPORTS-1:0]                  port_busy,
  input  logic [NPORTS-1:0]                  in_valid,
  output logic [NPORTS-1:0]                  in_ready,
  input  logic [NPORTS-1:0][DATA_W-1:0]      in_data,
  output logic [NPORTS-1:0]                  out_valid,
  input  logic [NPORTS-1:0]                  out_ready,
  output logic [NPORTS-1:0][DATA_W-1:0]      out_data
);
  logic [NPORTS-1:0][PORT_W-1:0] dest;
  logic [NPORTS-1:0]             dest_ok;
  logic [NPORTS-1:0]             busy;
  logic [NPORTS-1:0][PORT_W-1:0] peer;
  logic [NPORTS-1:0]             grant;
  logic [NPORTS-1:0]             kill;
  logic [NPORTS-1:0]             rsp_v_d;
  logic [NPORTS-1:0][1:0]        rsp_k_d;

  xbar_route_decode #(.NPORTS(NPORTS), .HOPS(HOPS), .PORT_W(PORT_W), .IDX_W(IDX_W)) u_dec (
    .route(req_route), .index(req_index), .dest(dest), .dest_ok(dest_ok));

  xbar_arbiter #(.NPORTS(NPORTS), .PORT_W(PORT_W), .LEN_W(LEN_W)) u_arb (
    .req_valid(req_valid), .req_kind(req_kind), .dest(dest), .dest_ok(dest_ok),
    .req_len(req_len), .busy(busy), .grant(grant), .kill(kill),
    .rsp_v_d(rsp_v_d), .rsp_k_d(rsp_k_d));

  xbar_link_table #(.NPORTS(NPORTS), .PORT_W(PORT_W), .LEN_W(LEN_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .grant(grant), .dest(dest), .req_len(req_len),
    .kill(kill), .busy(busy), .peer(peer));

  xbar_data_mux #(.NPORTS(NPORTS), .PORT_W(PORT_W), .DATA_W(DATA_W)) u_mux (
    .busy(busy), .peer(peer), .in_valid(in_valid), .in_data(in_data),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_kind  <= '0;
    end else begin
      rsp_valid <= rsp_v_d;
      rsp_kind  <= rsp_k_d;
    end
  end

  assign port_busy = busy;

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    // R9: a response only answers a token from the previous cycle.
    a_r9_rsp_after_token: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[p] |-> $past(req_valid[p]));
    // R9: response codes are limited to acknowledge / not-acknowledge.
    a_r9_rsp_code: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[p] |-> (rsp_kind[p] == TK_ACK || rsp_kind[p] == TK_NACK));
    // R1: an acknowledged request leaves its port busy.
    a_r1_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[p] && rsp_kind[p] == TK_ACK && $past(req_kind[p]) == TK_REQ) |-> port_busy[p]);
    // R8: a self-targeted request is never granted.
    a_r8_no_self_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && dest[p] == PORT_W'(p)) |-> !grant[p]);
    // R2: a grant never targets a port that is already busy.
    a_r2_target_free: assert property (@(posedge clk) disable iff (!rst_n)
      grant[p] |-> !busy[dest[p]]);
  end
endmodule

// File: tb/tb_xbar_link_ctrl.sv
module tb_xbar_link_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 6;
  localparam int HOPS = 4;
  localparam int LW = 8;
  localparam int DW = 32;
  localparam int PW = $clog2(NP);
  localparam int IW = $clog2(HOPS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]              req_valid = '0;
  logic [NP-1:0][1:0]         req_kind = '0;
  logic [NP-1:0][HOPS*PW-1:0] req_route = '0;
  logic [NP-1:0][IW-1:0]      req_index = '0;
  logic [NP-1:0][LW-1:0]      req_len = '0;
  logic [NP-1:0]              rsp_valid;
  logic [NP-1:0][1:0]         rsp_kind;
  logic [NP-1:0]              port_busy;
  logic [NP-1:0]              in_valid = '0;
  logic [NP-1:0]              in_ready;
  logic [NP-1:0][DW-1:0]      in_data = '0;
  logic [NP-1:0]              out_valid;
  logic [NP-1:0]              out_ready = '0;
  logic [NP-1:0][DW-1:0]      out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbar_link_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_route(req_route), .req_index(req_index), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .port_busy(port_busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  int checks = 0;
  int fails = 0;

  // Stimulus intent per port
  bit s_on[NP];
  int s_kind[NP];
  int s_dest[NP];
  int s_len[NP];
  int s_idx[NP];

  // Reference model: remaining hold cycles and partner per port
  int m_rem[NP];
  int m_peer[NP];
  bit e_rv[NP];
  int e_rk[NP];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic put(input int p, input int kind, input int d, input int len);
    s_on[p] = 1'b1; s_kind[p] = kind; s_dest[p] = d; s_len[p] = len;
    s_idx[p] = (p + 1) % HOPS;
  endtask

  task automatic drive();
    for (int p = 0; p < NP; p++) begin
      logic [HOPS*PW-1:0] r;
      r = '1;
      r[s_idx[p]*PW +: PW] = PW'(s_dest[p]);
      req_valid[p] = s_on[p];
      req_kind[p]  = 2'(s_kind[p]);
      req_route[p] = r;
      req_index[p] = IW'(s_idx[p]);
      req_len[p]   = LW'(s_len[p]);
    end
  endtask

  function automatic void model_step();
    bit taken[NP];
    bit killed[NP];
    bit fresh[NP];
    for (int p = 0; p < NP; p++) begin
      taken[p] = (m_rem[p] != 0); killed[p] = 0; fresh[p] = 0; e_rv[p] = 0; e_rk[p] = 2;
    end
    for (int i = 0; i < NP; i++) begin
      if (!s_on[i]) continue;
      if (s_kind[i] == 0) begin
        int d = s_dest[i];
        e_rv[i] = 1;
        if (d < NP && d != i && s_len[i] != 0 && !taken[i] && !taken[d]) begin
          taken[i] = 1; taken[d] = 1; fresh[i] = 1; fresh[d] = 1;
          m_rem[i] = s_len[i] + 1; m_rem[d] = s_len[i] + 1;
          m_peer[i] = d; m_peer[d] = i;
          e_rk[i] = 1;
        end
      end else if (s_kind[i] == 3) begin
        int d = s_dest[i];
        e_rv[i] = 1;
        if (d < NP && m_rem[d] != 0 && !fresh[d]) begin
          killed[d] = 1; killed[m_peer[d]] = 1; e_rk[i] = 1;
        end
      end
    end
    for (int p = 0; p < NP; p++) begin
      if (killed[p]) m_rem[p] = 0;
      else if (m_rem[p] > 0) m_rem[p]--;
    end
  endfunction

  task automatic compare(input string tag);
    for (int p = 0; p < NP; p++) begin
      chk(port_busy[p] == (m_rem[p] != 0), tag, $sformatf("busy port %0d", p),
          port_busy[p], m_rem[p] != 0);
      chk(rsp_valid[p] == e_rv[p], tag, $sformatf("rsp_valid port %0d", p),
          rsp_valid[p], e_rv[p]);
      if (e_rv[p] && rsp_valid[p])
        chk(rsp_kind[p] == 2'(e_rk[p]), tag, $sformatf("rsp_kind port %0d", p),
            rsp_kind[p], e_rk[p]);
    end
  endtask

  task automatic tick(input string tag);
    drive();
    model_step();
    @(negedge clk);
    compare(tag);
    for (int p = 0; p < NP; p++) s_on[p] = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      s_on[p] = 0; s_kind[p] = 0; s_dest[p] = 7; s_len[p] = 0; s_idx[p] = 0;
      m_rem[p] = 0; m_peer[p] = 0; e_rv[p] = 0; e_rk[p] = 2;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int p = 0; p < NP; p++) begin
      chk(port_busy[p] == 1'b0, "R1", "busy in reset", port_busy[p], 0);
      chk(rsp_valid[p] == 1'b0, "R1", "rsp in reset", rsp_valid[p], 0);
    end
    rst_n = 1'b1;
    idle(2, "R1");

    // R1 / R4: simple link, watch exact expiry
    put(0, 0, 3, 5); tick("R1");
    idle(7, "R4");

    // R2: port busy as either end
    put(0, 0, 2, 6); tick("R2");
    put(4, 0, 2, 3); put(2, 0, 5, 3); tick("R2");
    put(4, 0, 0, 3); tick("R2");
    idle(7, "R2");

    // R3: same target, lowest port wins
    put(1, 0, 4, 4); put(3, 0, 4, 4); put(5, 0, 4, 4); tick("R3");
    idle(5, "R3");
    put(0, 0, 1, 3); put(2, 0, 1, 3); put(3, 0, 5, 3); put(4, 0, 3, 3); tick("R3");
    idle(5, "R3");

    // R4: length 1 and length 0
    put(2, 0, 3, 1); put(4, 0, 5, 0); tick("R4");
    idle(3, "R4");

    // R5: invalid targets 6 and 7
    put(1, 0, 6, 4); put(2, 0, 7, 4); tick("R5");
    idle(2, "R5");

    // R6: ack/nack tokens ignored
    put(0, 1, 3, 4); put(1, 2, 4, 4); tick("R6");
    idle(2, "R6");

    // R7: preempt tears down, same-cycle request still blocked
    put(1, 0, 4, 50); tick("R7");
    idle(2, "R7");
    put(0, 3, 4, 0); put(2, 0, 1, 5); tick("R7");
    put(2, 0, 1, 5); tick("R7");
    put(3, 3, 0, 0); tick("R7");
    idle(7, "R7");

    // R8: self target
    put(3, 0, 3, 4); tick("R8");
    idle(2, "R8");

    // R10: two-way data path with ready pass-through
    put(0, 0, 5, 20); tick("R10");
    in_valid[0] = 1'b1; in_data[0] = 32'hA5A5_0001;
    in_valid[5] = 1'b1; in_data[5] = 32'h5A5A_0005;
    out_ready[5] = 1'b0; out_ready[0] = 1'b1;
    in_valid[2] = 1'b1; in_data[2] = 32'h1234_5678; out_ready[2] = 1'b1;
    #1;
    chk(out_valid[5] == 1'b1, "R10", "out_valid[5]", out_valid[5], 1);
    chk(out_data[5] == 32'hA5A5_0001, "R10", "out_data[5]", out_data[5], 32'hA5A5_0001);
    chk(out_data[0] == 32'h5A5A_0005, "R10", "out_data[0]", out_data[0], 32'h5A5A_0005);
    chk(in_ready[0] == 1'b0, "R10", "in_ready[0] stalled", in_ready[0], 0);
    chk(in_ready[5] == 1'b1, "R10", "in_ready[5]", in_ready[5], 1);
    chk(out_valid[2] == 1'b0 && out_data[2] == '0 && in_ready[2] == 1'b0,
        "R10", "idle port 2 quiet", {out_valid[2], in_ready[2]}, 0);
    out_ready[5] = 1'b1;
    #1;
    chk(in_ready[0] == 1'b1, "R10", "in_ready[0] released", in_ready[0], 1);
    in_valid = '0; out_ready = '0; in_data = '0;
    idle(22, "R10");

    // R3 / R2 / R7: mixed traffic against the model
    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < NP; p++) begin
        if (($urandom % 4) == 0) begin
          int k = $urandom % 8;
          put(p, (k < 5) ? 0 : (k == 7 ? 3 : (k == 6 ? 1 : 0)), $urandom % 8, $urandom % 12);
          s_idx[p] = $urandom % HOPS;
        end
      end
      tick("R3");
    end

    summary();
    $finish;
  end
endmodule